// File: doc/BRIEF.md
# Stepped-Width Retriggerable One-Shot

This block issues one output pulse each time a trigger edge arrives while it is idle. Three trigger lines choose how the width of the new pulse relates to the width of the pulse before it. The hold line repeats the width. The shorten line removes one step. The lengthen line adds one step. Changes carry over from one trigger to the next, so a run of lengthen triggers keeps stretching the pulse.

A tick divider, restarted by every accepted trigger, sets the step length. Each accepted trigger opens a busy window of fixed length. The pulse rises with the window and falls when a wrapping phase counter, which advances only on ticks inside the window, reaches its terminal value. The width is never stored as a number. It is the phase that counter holds between windows. A shorten trigger inserts one extra advance early in the window. A lengthen trigger suppresses the advance on the first tick. After reset, a burst of one advance per clock moves the phase so that the first pulse is INIT_WIDTH steps long.

Top module: `stepped_oneshot`

## Requirements
- R1: During and after reset, `pulse_o` and `busy_o` are low, and the first pulse after reset lasts INIT_WIDTH steps (one step is TICK_DIV clock cycles).
- R2: A rising edge on any `trig_i` bit while idle raises `busy_o` and `pulse_o` together, three clock edges after the input changes.
- R3: `busy_o` stays high for exactly WINDOW_TICKS steps, and `pulse_o` is high only while `busy_o` is high.
- R4: An edge on `trig_i[0]` (hold) gives a pulse of the same width as the previous pulse.
- R5: An edge on `trig_i[1]` (shorten) gives a pulse one step shorter than the previous pulse, and successive shortenings accumulate.
- R6: An edge on `trig_i[2]` (lengthen) gives a pulse one step longer than the previous pulse, and successive lengthenings accumulate.
- R7: The width never drops below one step. A shorten trigger at a width of one step leaves it at one step.
- R8: The width never exceeds WINDOW_TICKS steps, and the pulse always ends no later than its window. A lengthen trigger at the maximum leaves the width unchanged.
- R9: Trigger edges whose third clock edge falls inside the busy window, including the edge on which the window closes, start no pulse and do not change the width.
- R10: A trigger edge reaching its third clock edge on the first idle cycle after a window is accepted, and its adjustment applies to the new pulse.
- R11: When edges rise on several trigger bits in the same cycle, lengthen takes priority over shorten, and shorten takes priority over hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_i | input | 3 | Trigger lines: bit 0 hold, bit 1 shorten, bit 2 lengthen (asynchronous) |
| pulse_o | output | 1 | Stepped-width one-shot output |
| busy_o | output | 1 | High for the fixed window that follows an accepted trigger |

## Verification
Two things can happen in the same cycle: the trigger latches clear as the window closes, and a new trigger edge is accepted on the first idle cycle. The bench counts clock cycles from the start of a window. It raises the lengthen line so that its synchronized edge lands on the closing edge, and checks that no pulse follows and that the width is unchanged. It then raises the line one cycle later and checks that a new window opens on the very next cycle with a pulse one step longer. A third variant raises the line in the middle of the window to confirm that ordinary busy-time edges are dropped.

// File: rtl/oneshot_pkg.sv
package oneshot_pkg;
   typedef enum logic [1:0] {
      K_NONE = 2'd0,
      K_HOLD = 2'd1,
      K_DEC  = 2'd2,
      K_INC  = 2'd3
   } trig_kind_e;
endpackage

// File: rtl/os_trig_capture.sv
module os_trig_capture
   import oneshot_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [2:0] trig_i,
   input  logic       accept_en_i,
   input  logic       busy_i,
   output logic       start_o,
   output trig_kind_e start_kind_o,
   output trig_kind_e kind_q_o
);
   localparam int N_LINES = 3;

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   logic [N_LINES-1:0] rise;

   for (genvar g = 0; g < N_LINES; g++) begin : g_line
      logic [SYNC_STAGES:0] shift_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) shift_q <= '0;
         else        shift_q <= {shift_q[SYNC_STAGES-1:0], trig_i[g]};
      end
      assign rise[g] = shift_q[SYNC_STAGES-1] & ~shift_q[SYNC_STAGES];
   end

   assign start_o = accept_en_i & ~busy_i & (|rise);

   always_comb begin
      if (rise[2])      start_kind_o = K_INC;
      else if (rise[1]) start_kind_o = K_DEC;
      else              start_kind_o = K_HOLD;
   end

   logic busy_d;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_d   <= 1'b0;
         kind_q_o <= K_NONE;
      end else begin
         busy_d <= busy_i;
         if (start_o)                kind_q_o <= start_kind_o;
         else if (busy_d && !busy_i) kind_q_o <= K_NONE;
      end
   end

   // R9
   kind_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy_i && $past(busy_i) |-> $stable(kind_q_o));
endmodule

// File: rtl/os_tick_gen.sv
module os_tick_gen #(
   parameter int TICK_DIV     = 20,
   parameter int WINDOW_TICKS = 40
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   output logic busy_o,
   output logic tick_o,
   output logic adj_o
);
   localparam int DIV_W  = $clog2(TICK_DIV);
   localparam int WT_W   = $clog2(WINDOW_TICKS);
   localparam int ADJ_AT = TICK_DIV / 5;

   if (TICK_DIV < 5) begin : g_bad_div
      $error("TICK_DIV must be at least 5");
   end
   if (WINDOW_TICKS < 2) begin : g_bad_win
      $error("WINDOW_TICKS must be at least 2");
   end

   logic [DIV_W-1:0] div_q;
   logic [WT_W-1:0]  wt_q;

   assign tick_o = busy_o && (div_q == DIV_W'(TICK_DIV - 1));
   assign adj_o  = busy_o && (wt_q == '0) && (div_q == DIV_W'(ADJ_AT));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_o <= 1'b0;
         div_q  <= '0;
         wt_q   <= '0;
      end else if (start_i) begin
         busy_o <= 1'b1;
         div_q  <= '0;
         wt_q   <= '0;
      end else if (busy_o) begin
         if (tick_o) begin
            div_q <= '0;
            wt_q  <= wt_q + 1'b1;
            if (wt_q == WT_W'(WINDOW_TICKS - 1)) busy_o <= 1'b0;
         end else begin
            div_q <= div_q + 1'b1;
         end
      end
   end

   // R3
   window_ends_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_o) |-> $past(tick_o));
endmodule

// File: rtl/os_width_phase.sv
module os_width_phase
   import oneshot_pkg::*;
#(
   parameter int WINDOW_TICKS = 40,
   parameter int INIT_WIDTH   = 20
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start_i,
   input  trig_kind_e start_kind_i,
   input  trig_kind_e kind_q_i,
   input  logic       tick_i,
   input  logic       adj_i,
   output logic       ready_o,
   output logic       term_o
);
   localparam int PH_W    = $clog2(WINDOW_TICKS);
   localparam int PRE_W   = $clog2(WINDOW_TICKS + 1);
   localparam int PRELOAD = WINDOW_TICKS - INIT_WIDTH;
   localparam logic [PH_W-1:0] PH_LAST = PH_W'(WINDOW_TICKS - 1);

   if (INIT_WIDTH < 1 || INIT_WIDTH > WINDOW_TICKS) begin : g_bad_init
      $error("INIT_WIDTH must lie in 1..WINDOW_TICKS");
   end

   logic [PH_W-1:0]  ph_q;
   logic [PRE_W-1:0] pre_q;
   logic             swallow_q;

   function automatic logic [PH_W-1:0] advance(input logic [PH_W-1:0] p);
      return (p == PH_LAST) ? '0 : p + 1'b1;
   endfunction

   assign ready_o = (pre_q == '0);
   assign term_o  = ready_o && tick_i && !swallow_q && (ph_q == PH_LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q      <= '0;
         pre_q     <= PRE_W'(PRELOAD);
         swallow_q <= 1'b0;
      end else if (!ready_o) begin
         ph_q  <= advance(ph_q);
         pre_q <= pre_q - 1'b1;
      end else if (start_i) begin
         swallow_q <= (start_kind_i == K_INC) && (ph_q != '0);
      end else if (adj_i && kind_q_i == K_DEC && ph_q != PH_LAST) begin
         ph_q <= advance(ph_q);
      end else if (tick_i) begin
         if (swallow_q) swallow_q <= 1'b0;
         else           ph_q      <= advance(ph_q);
      end
   end

   // R7
   no_early_term_chk: assert property (@(posedge clk) disable iff (!rst_n)
      term_o |-> !$past(start_i));
endmodule

// File: rtl/stepped_oneshot.sv
module stepped_oneshot
   import oneshot_pkg::*;
#(
   parameter int TICK_DIV     = 20,
   parameter int WINDOW_TICKS = 40,
   parameter int INIT_WIDTH   = 20,
   parameter int SYNC_STAGES  = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [2:0] trig_i,
   output logic       pulse_o,
   output logic       busy_o
);
   logic       start, tick, adj, ready, term;
   trig_kind_e start_kind, kind_q;

   os_trig_capture #(.SYNC_STAGES(SYNC_STAGES)) u_cap (
      .clk(clk), .rst_n(rst_n), .trig_i(trig_i), .accept_en_i(ready),
      .busy_i(busy_o), .start_o(start), .start_kind_o(start_kind), .kind_q_o(kind_q)
   );

   os_tick_gen #(.TICK_DIV(TICK_DIV), .WINDOW_TICKS(WINDOW_TICKS)) u_tick (
      .clk(clk), .rst_n(rst_n), .start_i(start), .busy_o(busy_o),
      .tick_o(tick), .adj_o(adj)
   );

   os_width_phase #(.WINDOW_TICKS(WINDOW_TICKS), .INIT_WIDTH(INIT_WIDTH)) u_phase (
      .clk(clk), .rst_n(rst_n), .start_i(start), .start_kind_i(start_kind),
      .kind_q_i(kind_q), .tick_i(tick), .adj_i(adj), .ready_o(ready), .term_o(term)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     pulse_o <= 1'b0;
      else if (start) pulse_o <= 1'b1;
      else if (term)  pulse_o <= 1'b0;
   end

   // R3
   pulse_in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pulse_o |-> busy_o);
   // R2
   pulse_with_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_o) |-> pulse_o);
   // R9
   no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o && $past(busy_o) |-> !$rose(pulse_o));
   // R8
   pulse_ends_in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pulse_o) |-> $past(busy_o));
endmodule

// File: tb/sim_stepped_oneshot.sv
`timescale 1ns/1ps
module sim_stepped_oneshot;
   localparam int TD   = 20;
   localparam int WIN  = 40;
   localparam int INIT = 20;
   localparam int NSEQ = 8;
   // trigger bit index per step: 0 hold, 1 shorten, 2 lengthen; expected width in steps
   localparam int SEQ_BIT [NSEQ] = '{0, 2, 2, 0, 1, 1, 1, 2};
   localparam int SEQ_W   [NSEQ] = '{20, 21, 22, 22, 21, 20, 19, 20};

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] trig = 3'b000;
   logic       pulse_o, busy_o;
   int checks = 0;
   int errors = 0;
   int w_model = INIT;
   bit done = 0;

   always #2.5 clk = ~clk;

   stepped_oneshot #(.TICK_DIV(TD), .WINDOW_TICKS(WIN), .INIT_WIDTH(INIT), .SYNC_STAGES(2)) u0 (
      .clk(clk), .rst_n(rst_n), .trig_i(trig), .pulse_o(pulse_o), .busy_o(busy_o)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   function automatic int clampw(input int w);
      if (w < 1) return 1;
      if (w > WIN) return WIN;
      return w;
   endfunction

   // drive trigger bits, measure the pulse and the window that follow
   task automatic fire(input logic [2:0] bits, output int pw, output int bw, output int rises);
      bit started = 0;
      bit prevp = 0;
      pw = 0; bw = 0; rises = 0;
      trig = bits;
      for (int k = 1; k < 3000; k++) begin
         @(negedge clk);
         if (k == 5) trig = 3'b000;
         if (busy_o) started = 1;
         if (pulse_o) pw++;
         if (busy_o) bw++;
         if (pulse_o && !prevp) rises++;
         prevp = pulse_o;
         if (started && !busy_o && k > 5) break;
      end
      trig = 3'b000;
   endtask

   task automatic step(input logic [2:0] bits, input int exp_w, input string req);
      int pw, bw, rs;
      fire(bits, pw, bw, rs);
      check(pw == exp_w * TD, req, pw, exp_w * TD);
      check(bw == WIN * TD, "R3", bw, WIN * TD);
      w_model = exp_w;
   endtask

   // hold pulse, then lengthen line raised at cycle 'offset' of the window
   task automatic edge_case(input int offset, input bit accept, input string req);
      bit started = 0;
      int i = -1;
      int pw1 = 0;
      int pw2 = 0;
      int b801 = 0;
      trig = 3'b001;
      for (int k = 1; k < 4000; k++) begin
         @(negedge clk);
         if (k == 5) trig[0] = 1'b0;
         if (!started && busy_o) started = 1;
         if (started) i++;
         if (i == offset) trig[2] = 1'b1;
         if (i >= 0 && i < 800 && pulse_o) pw1++;
         if (i == 801) b801 = busy_o;
         if (i >= 801 && pulse_o) pw2++;
         if (i == 1700) break;
      end
      trig = 3'b000;
      check(pw1 == w_model * TD, "R4", pw1, w_model * TD);
      check(b801 == int'(accept), req, b801, int'(accept));
      if (accept) begin
         check(pw2 == clampw(w_model + 1) * TD, req, pw2, clampw(w_model + 1) * TD);
         w_model = clampw(w_model + 1);
      end else begin
         check(pw2 == 0, req, pw2, 0);
      end
      repeat (20) @(negedge clk);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      finish_run();
   end

   initial begin
      int pw, bw, rs;
      // R1 reset state
      repeat (3) @(negedge clk);
      check(pulse_o == 1'b0, "R1", pulse_o, 0);
      check(busy_o == 1'b0, "R1", busy_o, 0);
      rst_n = 1'b1;
      repeat (40) @(negedge clk);
      check(pulse_o == 1'b0 && busy_o == 1'b0, "R1", {pulse_o, busy_o}, 0);

      // R2 latency: trigger changes at a negedge, window opens at the third posedge
      trig = 3'b001;
      repeat (2) @(negedge clk);
      check(busy_o == 1'b0, "R2", busy_o, 0);
      @(negedge clk);
      check(busy_o == 1'b1 && pulse_o == 1'b1, "R2", {busy_o, pulse_o}, 3);
      trig = 3'b000;
      wait (!busy_o);
      repeat (5) @(negedge clk);
      // that pulse is the first after reset: INIT steps (R1 width checked via table entry 0 next)

      // table of steps: R1 (first entry), R4 hold, R5 shorten, R6 lengthen
      for (int s = 0; s < NSEQ; s++) begin
         string rq;
         rq = (SEQ_BIT[s] == 0) ? ((s == 0) ? "R1" : "R4") : (SEQ_BIT[s] == 1) ? "R5" : "R6";
         step(3'(1 << SEQ_BIT[s]), SEQ_W[s], rq);
      end

      // R7 floor
      while (w_model > 1) step(3'b010, w_model - 1, "R5");
      step(3'b010, 1, "R7");
      step(3'b001, 1, "R7");
      step(3'b100, 2, "R6");

      // R8 ceiling
      while (w_model < WIN) step(3'b100, w_model + 1, "R6");
      step(3'b100, WIN, "R8");
      step(3'b010, WIN - 1, "R8");

      // R9 mid-window edge ignored, single pulse in window
      fire(3'b001, pw, bw, rs);
      check(rs == 1, "R9", rs, 1);
      edge_case(100, 1'b0, "R9");
      step(3'b001, w_model, "R9");
      // R9 edge landing on the closing edge is ignored
      edge_case(797, 1'b0, "R9");
      step(3'b001, w_model, "R9");
      // R10 edge on first idle cycle accepted with lengthen applied
      step(3'b010, w_model - 1, "R5");
      edge_case(798, 1'b1, "R10");

      // R11 priority
      step(3'b111, clampw(w_model + 1), "R11");
      step(3'b011, clampw(w_model - 1), "R11");
      step(3'b101, clampw(w_model + 1), "R11");

      finish_run();
   end
endmodule